// File: doc/BRIEF.md
# Timer Event Interrupt Router

This block sits between a bank of general purpose timers and the interrupt controller. Every timer has two comparators. Each comparator pulses an event when it matches, and the block latches that pulse as a pending flag for its source. Enable masks then decide which pending sources reach the outputs. A source may raise a numbered interrupt line, a non-maskable interrupt request, or a system reset request. The reset path exists only for the lower timers.

The interrupt line for a source comes from a 32-bit zone register made of 4-bit line-number fields. Timers whose indices differ by the pair distance (four by default) share one field per comparator, so partners always land on the same line. Line number 0 means the route is switched off. Line number 2 is held back for firmware. A separate mask lists lines that belong to an external bus, and a timer event never drives one of those lines. Software writes the four registers through a simple write port and clears pending flags with a clear vector.

Top module: `tev_router`

## Requirements
- R1: A pulse on an event input sets the pending flag of that source at the next clock. The flag holds until its bit in `evt_clr` is seen at a clock. If an event and a clear for the same source arrive in the same cycle, the flag is set.
- R2: The interrupt enable register (`wr_sel`=0) enables comparator-1 of timer t at bit t and comparator-2 at bit t+8. A pending source whose enable bit is 0 drives no interrupt line.
- R3: The line number for timer t and comparator c is the zone register (`wr_sel`=2) field starting at bit ((c==2 ? 4 : 0) + (t mod 4)) * 4. An enabled pending source raises `irq_lines[n]`, where n is that field's value.
- R4: A field value of 0 disables the route, and no line is raised for it.
- R5: A field value of 2 is reserved, and no line is raised for it.
- R6: When bit n of the bus-line mask (`wr_sel`=3, bits 15:0) is set, no timer event raises `irq_lines[n]`.
- R7: Timers t and t+4 share a field. A pending, enabled event from either one raises the same line, and the line stays high while either source is still pending.
- R8: In the NMI/reset register (`wr_sel`=1), bit t enables comparator-1 of timer t toward `nmi_req` and bit t+8 enables comparator-2. `nmi_req` is high while any such enabled source is pending.
- R9: Bit 24+t of the NMI/reset register lets either comparator of timer t raise `rst_req`, but only for timers 0 to 5. Bits 30 and 31 have no effect on `rst_req`.
- R10: A register write takes effect at the next clock. After reset, all registers and flags are zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_cmp1 | input | 8 | Comparator-1 event pulses, one bit per timer |
| evt_cmp2 | input | 8 | Comparator-2 event pulses, one bit per timer |
| evt_clr | input | 16 | Pending-flag clears; bit t is comparator-1 of timer t, bit t+8 is comparator-2 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 IRQ enable, 1 NMI/reset, 2 zone, 3 bus-line mask |
| wr_data | input | 32 | Register write data |
| irq_lines | output | 16 | Level interrupt lines, one per line number |
| nmi_req | output | 1 | Non-maskable interrupt request |
| rst_req | output | 1 | System reset request |

## Verification
The assertions check three things on every cycle. First, pending flags only rise after an event and always fall after a clear that has no event beside it. Second, a zone write lands in the next cycle. Third, lines 0 and 2 and any bus-owned line stay quiet, and the NMI and reset requests only appear while a suitable source is pending. The correct choice of line for each timer and comparator cannot be shown this way, and neither can the OR of shared pairs or the blocking of reset bits 30 and 31. Only the bench's scenarios can show these, comparing every output each cycle against a reference model built from the requirements.

// File: rtl/tev_pkg.sv
// Package: tev_pkg
// Shared register-select encoding for the timer event router.
// Assumes a two-bit select on the register write port.
package tev_pkg;

    typedef enum logic [1:0] {
        SEL_IRQ_EN  = 2'd0,
        SEL_NMI_RST = 2'd1,
        SEL_ZONE    = 2'd2,
        SEL_LPC     = 2'd3
    } tev_sel_e;

endpackage

// File: rtl/tev_pending.sv
// Module: tev_pending
// Holds one pending flag per event source. A pulse sets the flag and a
// clear bit drops it. When both arrive in the same cycle, the set wins.
// Assumes the event pulses are synchronous to clk.
module tev_pending #(
    parameter int SRC_N = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_set,
    input  logic [SRC_N-1:0] evt_clr,
    output logic [SRC_N-1:0] pend_q
);

    // Purpose: latch event pulses and apply software clears.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~evt_clr) | evt_set;
    end

    // R1: a flag only rises after an event pulse
    assert_set_needs_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(evt_set)) == '0));

    // R1: a clear that has no event beside it always drops the flag
    assert_clear_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((pend_q & $past(evt_clr & ~evt_set)) == '0));

endmodule

// File: rtl/tev_regs.sv
// Module: tev_regs
// Write-only configuration registers: the IRQ enable mask, the NMI and
// reset enables, the zone-select fields and the bus-line mask. Reset
// enables are kept only for the lower RST_TIMERS timers; the others are
// dropped at write time. Assumes one write per cycle at most.
module tev_regs
    import tev_pkg::*;
#(
    parameter int N_TIMERS   = 8,
    parameter int IRQ_W      = 16,
    parameter int REG_W      = 32,
    parameter int RST_TIMERS = 6,
    parameter int RST_BASE   = 24,
    parameter int ZONE_W     = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [REG_W-1:0]      wr_data,
    output logic [2*N_TIMERS-1:0] irq_en_q,
    output logic [2*N_TIMERS-1:0] nmi_en_q,
    output logic [RST_TIMERS-1:0] rst_en_q,
    output logic [ZONE_W-1:0]     zone_q,
    output logic [IRQ_W-1:0]      lpc_q
);

    localparam int SRC_N = 2 * N_TIMERS;

    tev_sel_e sel;
    logic     unused_wdata;

    assign sel          = tev_sel_e'(wr_sel);
    assign unused_wdata = ^wr_data;

    // Purpose: load the selected register on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_en_q <= '0;
            nmi_en_q <= '0;
            rst_en_q <= '0;
            zone_q   <= '0;
            lpc_q    <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_IRQ_EN:  irq_en_q <= wr_data[SRC_N-1:0];
                SEL_NMI_RST: begin
                    nmi_en_q <= wr_data[SRC_N-1:0];
                    rst_en_q <= wr_data[RST_BASE +: RST_TIMERS];
                end
                SEL_ZONE:    zone_q <= wr_data[ZONE_W-1:0];
                default:     lpc_q  <= wr_data[IRQ_W-1:0];
            endcase
        end
    end

    // R10: a zone write is visible at the next clock
    assert_zone_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $past(wr_sel) == 2'd2)
        |-> (zone_q == $past(wr_data[ZONE_W-1:0])));

    // R10: registers not selected keep their value
    assert_lpc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(wr_en) && $past(wr_sel) == 2'd3)) |-> $stable(lpc_q));

endmodule

// File: rtl/tev_irq_map.sv
// Module: tev_irq_map
// Turns pending, enabled sources into a vector of level interrupt lines.
// Each source reads its line number from a zone field shared with its
// pair partner. Numbers 0 (off) and RSVD_NUM (firmware) are blocked, and so
// are lines owned by the bus. Assumes IRQ_W is a power of two.
module tev_irq_map #(
    parameter int N_TIMERS   = 8,
    parameter int ZONE_GROUP = 4,
    parameter int IRQ_W      = 16,
    parameter int RSVD_NUM   = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [2*N_TIMERS-1:0]   pend,
    input  logic [2*N_TIMERS-1:0]   irq_en,
    input  logic [2*ZONE_GROUP*$clog2(IRQ_W)-1:0] zone,
    input  logic [IRQ_W-1:0]        lpc,
    output logic [IRQ_W-1:0]        irq_out
);

    localparam int SRC_N = 2 * N_TIMERS;
    localparam int NUM_W = $clog2(IRQ_W);

    logic [IRQ_W-1:0] contrib [SRC_N];

    for (genvar s = 0; s < SRC_N; s++) begin : g_src
        localparam int TIM  = s % N_TIMERS;
        localparam int CMP  = s / N_TIMERS;
        localparam int BASE = (CMP * ZONE_GROUP + (TIM % ZONE_GROUP)) * NUM_W;

        logic [NUM_W-1:0] num;
        logic             usable;

        assign num = zone[BASE +: NUM_W];

        // Purpose: decide whether this source drives its line, and which one.
        always_comb begin
            usable = pend[s] && irq_en[s] && (num != '0)
                     && (num != NUM_W'(RSVD_NUM)) && !lpc[num];
            contrib[s] = usable ? (IRQ_W'(1) << num) : '0;
        end
    end

    // Purpose: merge all sources so shared fields combine by OR.
    always_comb begin
        irq_out = '0;
        for (int s = 0; s < SRC_N; s++) irq_out |= contrib[s];
    end

    // R4: line 0 is never raised
    assert_line_zero_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[0] == 1'b0);

    // R5: the firmware-reserved line is never raised
    assert_reserved_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out[RSVD_NUM] == 1'b0);

    // R6: a bus-owned line is never raised
    assert_lpc_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & lpc) == '0);

    // R2: no line without an enabled pending source
    assert_line_needs_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out != '0) |-> ((pend & irq_en) != '0));

endmodule

// File: rtl/tev_nmi_rst.sv
// Module: tev_nmi_rst
// Folds pending sources into the NMI and system reset requests. Reset
// requests come only from the lower RST_TIMERS timers, from either
// comparator. Assumes RST_TIMERS <= N_TIMERS.
module tev_nmi_rst #(
    parameter int N_TIMERS   = 8,
    parameter int RST_TIMERS = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*N_TIMERS-1:0] pend,
    input  logic [2*N_TIMERS-1:0] nmi_en,
    input  logic [RST_TIMERS-1:0] rst_en,
    output logic                  nmi_req,
    output logic                  rst_req
);

    logic [RST_TIMERS-1:0] tim_pend;

    // Purpose: merge both comparators of each reset-capable timer.
    always_comb begin
        for (int t = 0; t < RST_TIMERS; t++)
            tim_pend[t] = pend[t] | pend[N_TIMERS + t];
    end

    // Purpose: form the two request outputs.
    always_comb begin
        nmi_req = |(pend & nmi_en);
        rst_req = |(tim_pend & rst_en);
    end

    // R8: the NMI request needs some pending source
    assert_nmi_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req |-> (pend != '0));

    // R9: a reset request needs a pending reset-capable timer
    assert_rst_low_timers_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> ((pend[RST_TIMERS-1:0] | pend[N_TIMERS +: RST_TIMERS]) != '0));

endmodule

// File: rtl/tev_router.sv
// Module: tev_router (top)
// Routes comparator events from N_TIMERS timers to level interrupt lines,
// an NMI request and a reset request. All state is registered: an event
// or a register write changes the outputs just after the next clock edge.
// Assumes CMP2 enables sit at bit t+N_TIMERS and reset enables at RST_BASE+t.
module tev_router #(
    parameter int N_TIMERS   = 8,
    parameter int ZONE_GROUP = 4,
    parameter int IRQ_W      = 16,
    parameter int REG_W      = 32,
    parameter int RST_TIMERS = 6,
    parameter int RST_BASE   = 24,
    parameter int RSVD_NUM   = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_TIMERS-1:0]   evt_cmp1,
    input  logic [N_TIMERS-1:0]   evt_cmp2,
    input  logic [2*N_TIMERS-1:0] evt_clr,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [REG_W-1:0]      wr_data,
    output logic [IRQ_W-1:0]      irq_lines,
    output logic                  nmi_req,
    output logic                  rst_req
);

    localparam int SRC_N  = 2 * N_TIMERS;
    localparam int NUM_W  = $clog2(IRQ_W);
    localparam int ZONE_W = 2 * ZONE_GROUP * NUM_W;

    logic [SRC_N-1:0]      pend;
    logic [SRC_N-1:0]      irq_en;
    logic [SRC_N-1:0]      nmi_en;
    logic [RST_TIMERS-1:0] rst_en;
    logic [ZONE_W-1:0]     zone;
    logic [IRQ_W-1:0]      lpc;

    tev_pending #(.SRC_N(SRC_N)) u_pending (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_set ({evt_cmp2, evt_cmp1}),
        .evt_clr (evt_clr),
        .pend_q  (pend)
    );

    tev_regs #(
        .N_TIMERS   (N_TIMERS),
        .IRQ_W      (IRQ_W),
        .REG_W      (REG_W),
        .RST_TIMERS (RST_TIMERS),
        .RST_BASE   (RST_BASE),
        .ZONE_W     (ZONE_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .irq_en_q (irq_en),
        .nmi_en_q (nmi_en),
        .rst_en_q (rst_en),
        .zone_q   (zone),
        .lpc_q    (lpc)
    );

    tev_irq_map #(
        .N_TIMERS   (N_TIMERS),
        .ZONE_GROUP (ZONE_GROUP),
        .IRQ_W      (IRQ_W),
        .RSVD_NUM   (RSVD_NUM)
    ) u_irq_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .irq_en  (irq_en),
        .zone    (zone),
        .lpc     (lpc),
        .irq_out (irq_lines)
    );

    tev_nmi_rst #(
        .N_TIMERS   (N_TIMERS),
        .RST_TIMERS (RST_TIMERS)
    ) u_nmi_rst (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .nmi_en  (nmi_en),
        .rst_en  (rst_en),
        .nmi_req (nmi_req),
        .rst_req (rst_req)
    );

endmodule

// File: tb/tev_router_bench.sv
// Bench for tev_router. A behavioural reference model is advanced at each
// rising edge and compared with all outputs at every falling edge.
module tev_router_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  b_e1 = '0, b_e2 = '0;
    logic [15:0] b_clr = '0;
    logic        b_we = 1'b0;
    logic [1:0]  b_sel = '0;
    logic [31:0] b_data = '0;

    logic [15:0] irq_lines;
    logic        nmi_req, rst_req;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_req = "R10";

    // reference model state
    bit          m_pend [16];
    logic [31:0] m_irqm, m_nr, m_zsel, m_lpc;

    always #5 clk = ~clk;

    tev_router u_tev_router (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_cmp1  (b_e1),
        .evt_cmp2  (b_e2),
        .evt_clr   (b_clr),
        .wr_en     (b_we),
        .wr_sel    (b_sel),
        .wr_data   (b_data),
        .irq_lines (irq_lines),
        .nmi_req   (nmi_req),
        .rst_req   (rst_req)
    );

    task automatic model_update();
        if (!rst_n) begin
            foreach (m_pend[i]) m_pend[i] = 0;
            m_irqm = 0; m_nr = 0; m_zsel = 0; m_lpc = 0;
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (b_clr[i])     m_pend[i] = 0;
                if (b_clr[i + 8]) m_pend[i + 8] = 0;
                if (b_e1[i])      m_pend[i] = 1;
                if (b_e2[i])      m_pend[i + 8] = 1;
            end
            if (b_we) begin
                case (b_sel)
                    2'd0: m_irqm = b_data;
                    2'd1: m_nr   = b_data;
                    2'd2: m_zsel = b_data;
                    default: m_lpc = b_data;
                endcase
            end
        end
    endtask

    task automatic compare();
        logic [15:0] e_irq = '0;
        bit e_nmi = 0, e_rst = 0;
        for (int c = 0; c < 2; c++) begin
            for (int t = 0; t < 8; t++) begin
                int s = c * 8 + t;
                int f = (m_zsel >> (((c == 1 ? 4 : 0) + t % 4) * 4)) & 15;
                if (m_pend[s] && m_irqm[s] && f != 0 && f != 2 && !m_lpc[f])
                    e_irq[f] = 1'b1;
                if (m_pend[s] && m_nr[s]) e_nmi = 1;
            end
        end
        for (int t = 0; t < 6; t++)
            if ((m_pend[t] || m_pend[t + 8]) && m_nr[24 + t]) e_rst = 1;
        checks += 3;
        if (irq_lines !== e_irq) begin
            errors++;
            $display("FAIL %s irq_lines got %h expected %h at %0t", cur_req, irq_lines, e_irq, $time);
        end
        if (nmi_req !== e_nmi) begin
            errors++;
            $display("FAIL %s nmi_req got %b expected %b at %0t", cur_req, nmi_req, e_nmi, $time);
        end
        if (rst_req !== e_rst) begin
            errors++;
            $display("FAIL %s rst_req got %b expected %b at %0t", cur_req, rst_req, e_rst, $time);
        end
    endtask

    task automatic step(input logic [7:0] e1, input logic [7:0] e2, input logic [15:0] cl,
                        input logic we, input logic [1:0] sel, input logic [31:0] d);
        b_e1 = e1; b_e2 = e2; b_clr = cl; b_we = we; b_sel = sel; b_data = d;
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        step('0, '0, '0, 1'b1, sel, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0, 1'b0, 2'd0, '0);
    endtask

    task automatic ev(input logic [7:0] e1, input logic [7:0] e2);
        step(e1, e2, '0, 1'b0, 2'd0, '0);
    endtask

    task automatic clr(input logic [15:0] c);
        step('0, '0, c, 1'b0, 2'd0, '0);
    endtask

    // watchdog: a hung run is a failed check
    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog expired got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R10: reset state, outputs low even with events applied
        cur_req = "R10";
        rst_n = 1'b0;
        step(8'hFF, 8'hFF, '0, 1'b1, 2'd0, 32'hFFFF_FFFF);
        step('0, '0, '0, 1'b0, 2'd0, '0);
        rst_n = 1'b1;
        idle(2);
        wr(2'd0, 32'h0000_FFFF);
        ev(8'h08, 8'h00);              // pending but zone 0: no line (R4 too)
        cur_req = "R4";
        idle(2);
        clr(16'hFFFF);

        // R3: timer 3 cmp1 field bits 15:12 = 5; timer 1 cmp2 field bits 23:20 = 9
        cur_req = "R3";
        wr(2'd2, 32'h0090_5000);
        ev(8'h08, 8'h02);
        idle(3);

        // R1: clear one source, then set and clear together
        cur_req = "R1";
        clr(16'h0008);
        idle(1);
        step(8'h08, 8'h00, 16'h0008, 1'b0, 2'd0, '0);
        idle(1);
        clr(16'hFFFF);
        idle(1);

        // R2: disable cmp2 of timer 1 (bit 9) while pending
        cur_req = "R2";
        ev(8'h00, 8'h02);
        wr(2'd0, 32'h0000_FDFF);
        idle(1);
        wr(2'd0, 32'h0000_FFFF);
        clr(16'hFFFF);

        // R5: field value 2 for timer 0 cmp1
        cur_req = "R5";
        wr(2'd2, 32'h0000_0002);
        ev(8'h01, 8'h00);
        idle(2);
        clr(16'hFFFF);

        // R6: line 5 owned by the bus
        cur_req = "R6";
        wr(2'd2, 32'h0000_5000);
        wr(2'd3, 32'h0000_0020);
        ev(8'h08, 8'h00);
        idle(1);
        wr(2'd3, 32'h0000_0000);
        idle(1);
        clr(16'hFFFF);

        // R7: timers 2 and 6 share field bits 11:8 = 11
        cur_req = "R7";
        wr(2'd2, 32'h0000_0B00);
        ev(8'h04, 8'h00);
        ev(8'h40, 8'h00);
        clr(16'h0004);
        idle(1);
        clr(16'h0040);
        idle(1);

        // R8: NMI enables on cmp1 timer 7 (bit 7) and cmp2 timer 0 (bit 8)
        cur_req = "R8";
        wr(2'd1, 32'h0000_0180);
        ev(8'h80, 8'h00);
        clr(16'h0080);
        ev(8'h00, 8'h01);
        clr(16'hFFFF);
        ev(8'h01, 8'h00);
        clr(16'hFFFF);

        // R9: bits 30 and 31 ignored; bit 29 (timer 5) active from either comparator
        cur_req = "R9";
        wr(2'd1, 32'hC000_0000);
        ev(8'hC0, 8'hC0);
        idle(1);
        clr(16'hFFFF);
        wr(2'd1, 32'h2000_0000);
        ev(8'h00, 8'h20);
        clr(16'hFFFF);
        ev(8'h20, 8'h00);
        clr(16'hFFFF);

        // R2: mixed traffic over all registers
        cur_req = "R2";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] d = $urandom;
            step(r[7:0] & r[15:8], r[23:16] & r[31:24], 16'($urandom) & 16'($urandom),
                 (i % 5) == 0, 2'(i / 5), d);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule